// File: doc/BRIEF.md
# SPI Board Management Register Slave

This block is an SPI slave that gives a host processor access to a small set of 8-bit board-management registers. It drives four LED outputs and eight byte-wide control outputs, which cover power enables, several peripheral resets, two optical-cage controls, a warm reset, a warm-reset key and a power-management-bus select. It reports push-button and DIP-switch levels, three power-good status bytes and an I2C master-select status byte. Every level change on a button or switch input sets a sticky change flag. The OR of all flags drives an interrupt output, and the host clears the flags through a write-one-to-clear register.

Each select period carries exactly one access. The host first sends an address byte and then a data byte, both MSB first, in SPI mode 3. Bit 0 of the address chooses the direction: 1 reads and 0 writes. Every register therefore has an even address for writes and the next odd address for its read view. To change only some bits, the host reads the odd address and then writes the even address. The SPI pins are sampled by the system clock, so all register state stays in one clock domain.

Top module: `brd_ctl_spi_slave`

## Requirements
- R1: SPI runs in mode 3. SCK idles high, MOSI is sampled on rising SCK, and MISO changes only after falling SCK. A frame is an address byte followed by a data byte, MSB first. During the data phase of a read, MISO carries the read value MSB first, with bit 7 valid before the ninth rising edge.
- R2: A read of address 0x01 returns the VERSION parameter (default 0x3C).
- R3: A write to 0x02 drives `led_o[3:0]` with data bits 7:4. Data bits 3:0 are discarded. A read of 0x03 returns the LED nibble in bits 7:4 and zero in bits 3:0.
- R4: A read of 0x05 returns the synchronized level of `btn_sw_i`, bit for bit.
- R5: A change in any synchronized `btn_sw_i` bit sets the matching flag, which a read of 0x07 returns. `irq_o` is high exactly while any flag is set.
- R6: Writing 0x06 clears each flag whose data bit is 1 and keeps each flag whose data bit is 0. A flag is never cleared in a cycle in which a new change for that bit arrives.
- R7: Reads of 0x09, 0x0B and 0x0D return `pwr_good_i` bytes 0, 1 and 2 (bits 7:0, 15:8, 23:16). A read of 0x19 returns `i2c_sel_i`.
- R8: Writes to 0x0E, 0x10, 0x12, 0x14, 0x16, 0x1A, 0x1C and 0x1E store the data byte into `ctrl_o` bytes 0 to 7 in that order (byte k is bits 8k+7:8k). The byte is read back at the write address plus one.
- R9: Writes to unlisted even addresses, including 0x00, change no output or register. Reads of unlisted odd addresses return 0x00. MISO stays 0 during the data phase of a write.
- R10: A write commits only when all 16 bits arrive before chip select rises. A frame cut short changes nothing, and bits after the 16th are ignored.
- R11: After reset, `led_o`, `ctrl_o`, all flags, `irq_o` and `spi_miso` are 0, and input levels present at reset do not set flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock from host, idles high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when not reading |
| btn_sw_i | input | 8 | Push-button and DIP-switch levels (asynchronous) |
| pwr_good_i | input | 24 | Three power-good status bytes |
| i2c_sel_i | input | 8 | I2C master-select status byte |
| led_o | output | 4 | LED drive |
| ctrl_o | output | 64 | Eight control bytes, byte k at bits 8k+7:8k |
| irq_o | output | 1 | High while any change flag is set |

## Verification
The assertions assume that each SCK phase lasts at least four system clocks, so that the synchronizer sees every edge. They also assume that MOSI changes only while SCK is low and that chip select moves only while SCK is high. The bench keeps within these limits by holding each SCK phase for six clocks and by changing MOSI and SCK together on the falling edge. It leaves at least one high phase before and after each chip-select change. Button inputs are taken to be arbitrary asynchronous levels, and the bench exercises this by toggling one of them on every clock while a flag-clear write is in flight.

// File: rtl/brd_regs_pkg.sv
// Package: register widths and address decode constants shared by the
// board-management SPI slave. Assumes 8-bit registers and 8-bit addresses.
package brd_regs_pkg;
    localparam int DW       = 8;
    localparam int LED_W    = 4;
    localparam int NUM_CTRL = 8;
    localparam int NUM_PG   = 3;

    localparam logic [DW-1:0] ADR_VER_RD  = 8'h01;
    localparam logic [DW-1:0] ADR_LED_WR  = 8'h02;
    localparam logic [DW-1:0] ADR_LED_RD  = 8'h03;
    localparam logic [DW-1:0] ADR_BTN_RD  = 8'h05;
    localparam logic [DW-1:0] ADR_FLG_CLR = 8'h06;
    localparam logic [DW-1:0] ADR_FLG_RD  = 8'h07;
    localparam logic [DW-1:0] ADR_I2C_RD  = 8'h19;

    localparam logic [DW-1:0] PG_ADDR [NUM_PG] = '{8'h09, 8'h0B, 8'h0D};
    localparam logic [DW-1:0] CTRL_ADDR [NUM_CTRL] =
        '{8'h0E, 8'h10, 8'h12, 8'h14, 8'h16, 8'h1A, 8'h1C, 8'h1E};
endpackage

// File: rtl/brd_spi_frontend.sv
// SPI mode-3 slave framing. Oversamples SCK, CS and MOSI with the system
// clock through two-flop synchronizers, captures an address byte and a data
// byte, and serializes a read value on MISO. Assumes each SCK phase spans at
// least four system clocks. One register access per chip-select period.
module brd_spi_frontend
    import brd_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic [DW-1:0] addr_o,
    output logic          wr_en_o,
    output logic [DW-1:0] wr_data_o,
    input  logic [DW-1:0] rd_data_i
);
    localparam int FRAME = 2 * DW;
    localparam int CNT_W = $clog2(FRAME + 1);

    logic [1:0]       sck_s, cs_s, mosi_s;
    logic             sck_d;
    logic             cs_act, rise, fall;
    logic [CNT_W-1:0] cnt;
    logic [DW-1:0]    sh, addr_q, tx;
    logic [DW-1:0]    sh_next;
    logic             addr_done, rd_phase;

    // Synchronize the SPI pins and keep one delayed SCK sample for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= 2'b11;
            cs_s   <= 2'b11;
            mosi_s <= 2'b00;
            sck_d  <= 1'b1;
        end else begin
            sck_s  <= {sck_s[0], spi_sck};
            cs_s   <= {cs_s[0], spi_cs_n};
            mosi_s <= {mosi_s[0], spi_mosi};
            sck_d  <= sck_s[1];
        end
    end

    assign cs_act  = ~cs_s[1];
    assign rise    = cs_act & sck_s[1] & ~sck_d;
    assign fall    = cs_act & ~sck_s[1] & sck_d;
    assign sh_next = {sh[DW-2:0], mosi_s[1]};

    // Shift in MOSI bits, count them, and latch the address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh     <= '0;
            addr_q <= '0;
        end else if (!cs_act) begin
            cnt <= '0;
        end else if (rise && cnt != CNT_W'(FRAME)) begin
            sh  <= sh_next;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(DW - 1)) addr_q <= sh_next;
        end
    end

    // Pulse after the address completes, and the write strobe on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_done <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            addr_done <= rise && cnt == CNT_W'(DW - 1);
            wr_en_o   <= rise && cnt == CNT_W'(FRAME - 1) && !addr_q[0];
            if (rise && cnt == CNT_W'(FRAME - 1)) wr_data_o <= sh_next;
        end
    end

    // Load the read value once the address is known, shift on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx       <= '0;
            rd_phase <= 1'b0;
        end else if (!cs_act) begin
            tx       <= '0;
            rd_phase <= 1'b0;
        end else if (addr_done && addr_q[0]) begin
            tx       <= rd_data_i;
            rd_phase <= 1'b1;
        end else if (fall && cnt > CNT_W'(DW) && cnt < CNT_W'(FRAME)) begin
            tx <= {tx[DW-2:0], 1'b0};
        end
    end

    assign spi_miso = rd_phase & tx[DW-1];
    assign addr_o   = addr_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME)); // R10
    AST_WR_ON_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> cnt == CNT_W'(FRAME)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> cnt == '0 && !spi_miso); // R11
endmodule

// File: rtl/brd_change_flags.sv
// Button and switch sampler. Synchronizes the asynchronous inputs with two
// flops, sets a sticky flag on any level change between successive samples,
// and clears flags by a one-hot mask where a fresh change wins over a clear.
// Change detection is held off for three cycles after reset.
module brd_change_flags
    import brd_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pins_i,
    input  logic [DW-1:0] clr_mask_i,
    output logic [DW-1:0] level_o,
    output logic [DW-1:0] flags_o,
    output logic          irq_o
);
    logic [DW-1:0] s0, s1, prev, chg, flags_q;
    logic [1:0]    arm;

    // Two-flop synchronizer, previous-sample register and arming counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0   <= '0;
            s1   <= '0;
            prev <= '0;
            arm  <= '0;
        end else begin
            s0   <= pins_i;
            s1   <= s0;
            prev <= s1;
            if (arm != 2'd3) arm <= arm + 2'd1;
        end
    end

    assign chg = (arm == 2'd3) ? (s1 ^ prev) : '0;

    // Sticky flags: set on change, cleared by mask, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_mask_i) | chg;
    end

    assign level_o = s1;
    assign flags_o = flags_q;
    assign irq_o   = |flags_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> (flags_q & $past(chg)) == $past(chg)); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags_q) & ~flags_q & ~$past(clr_mask_i)) == '0); // R6
endmodule

// File: rtl/brd_reg_bank.sv
// Register storage and decode. Holds the LED nibble and the control bytes,
// commits writes strobed by the SPI front end, forms the flag-clear mask and
// selects the read value for an odd address. Unlisted addresses read zero.
module brd_reg_bank
    import brd_regs_pkg::*;
#(
    parameter logic [DW-1:0] VERSION = 8'h3C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DW-1:0]          addr_i,
    input  logic                   wr_en_i,
    input  logic [DW-1:0]          wr_data_i,
    output logic [DW-1:0]          rd_data_o,
    input  logic [DW-1:0]          level_i,
    input  logic [DW-1:0]          flags_i,
    input  logic [NUM_PG*DW-1:0]   pwr_good_i,
    input  logic [DW-1:0]          i2c_sel_i,
    output logic [DW-1:0]          clr_mask_o,
    output logic [LED_W-1:0]       led_o,
    output logic [NUM_CTRL*DW-1:0] ctrl_o
);
    logic [LED_W-1:0] led_q;

    // LED register keeps only the upper data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                              led_q <= '0;
        else if (wr_en_i && addr_i == ADR_LED_WR) led_q <= wr_data_i[DW-1 -: LED_W];
    end

    // One storage byte per writable control address.
    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_o[k*DW +: DW] <= '0;
            else if (wr_en_i && addr_i == CTRL_ADDR[k])
                ctrl_o[k*DW +: DW] <= wr_data_i;
        end
    end

    assign clr_mask_o = (wr_en_i && addr_i == ADR_FLG_CLR) ? wr_data_i : '0;
    assign led_o      = led_q;

    // Read multiplexer over the odd addresses.
    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            ADR_VER_RD: rd_data_o = VERSION;
            ADR_LED_RD: rd_data_o = {led_q, {(DW-LED_W){1'b0}}};
            ADR_BTN_RD: rd_data_o = level_i;
            ADR_FLG_RD: rd_data_o = flags_i;
            ADR_I2C_RD: rd_data_o = i2c_sel_i;
            default:    rd_data_o = '0;
        endcase
        for (int k = 0; k < NUM_PG; k++)
            if (addr_i == PG_ADDR[k]) rd_data_o = pwr_good_i[k*DW +: DW];
        for (int k = 0; k < NUM_CTRL; k++)
            if (addr_i == (CTRL_ADDR[k] | 8'h01)) rd_data_o = ctrl_o[k*DW +: DW];
    end

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(led_q) && $stable(ctrl_o)); // R9
    AST_ODD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        addr_i[0] |-> clr_mask_o == '0); // R9
endmodule

// File: rtl/brd_ctl_spi_slave.sv
// Top level of the board-management SPI slave: connects the SPI front end,
// the button/switch change-flag sampler and the register bank. All state is
// clocked by clk; the SPI pins and button inputs are treated as asynchronous.
module brd_ctl_spi_slave
    import brd_regs_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h3C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic [7:0]  btn_sw_i,
    input  logic [23:0] pwr_good_i,
    input  logic [7:0]  i2c_sel_i,
    output logic [3:0]  led_o,
    output logic [63:0] ctrl_o,
    output logic        irq_o
);
    logic [DW-1:0] addr, wr_data, rd_data, clr_mask, level, flags;
    logic          wr_en;

    brd_spi_frontend u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .addr_o    (addr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .rd_data_i (rd_data)
    );

    brd_change_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (btn_sw_i),
        .clr_mask_i (clr_mask),
        .level_o    (level),
        .flags_o    (flags),
        .irq_o      (irq_o)
    );

    brd_reg_bank #(.VERSION(VERSION)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .level_i    (level),
        .flags_i    (flags),
        .pwr_good_i (pwr_good_i),
        .i2c_sel_i  (i2c_sel_i),
        .clr_mask_o (clr_mask),
        .led_o      (led_o),
        .ctrl_o     (ctrl_o)
    );

    AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (flags != '0)); // R5
endmodule

// File: tb/brd_ctl_spi_slave_tb.sv
// Scoreboard bench: the transfer task queues the expected MISO byte of each
// complete frame, and a monitor process compares it with the captured byte.
module brd_ctl_spi_slave_tb;
    localparam int CLK_NS = 10;
    localparam int HALF   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic [7:0]  btn = 8'h5A;
    logic [23:0] pg = 24'hC3_96_E1;
    logic [7:0]  i2c = 8'h27;
    logic [3:0]  led;
    logic [63:0] ctrl;
    logic        irq;

    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t        exp_q[$];
    logic [7:0]  rx_last;
    event        rd_done;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #(CLK_NS/2) clk = ~clk;

    brd_ctl_spi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .btn_sw_i(btn), .pwr_good_i(pg),
        .i2c_sel_i(i2c), .led_o(led), .ctrl_o(ctrl), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one frame of nbits bits; full frames queue the expected MISO byte.
    task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nbits,
                        input logic [7:0] third, input logic [7:0] exp, input string tag);
        logic [23:0] frame;
        logic [7:0]  rx;
        exp_t        it;
        frame = {a, d, third};
        rx = '0;
        if (nbits >= 16) begin
            it.v = exp; it.tag = tag;
            exp_q.push_back(it);
        end
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0; mosi = frame[23-i];
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 16) rx = {rx[6:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1; mosi = 1'b0;
        repeat (2*HALF) @(negedge clk);
        if (nbits >= 16) begin
            rx_last = rx;
            -> rd_done;
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        xfer(a, 8'h00, 16, 8'h00, exp, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        xfer(a, d, 16, 8'h00, 8'h00, tag);
    endtask

    // Monitor: compare each captured MISO byte with the queued expectation.
    initial begin
        exp_t it;
        forever begin
            @(rd_done);
            it = exp_q.pop_front();
            n_chk++;
            if (rx_last !== it.v) begin
                n_fail++;
                $display("FAIL %s: actual %02h expected %02h", it.tag, rx_last, it.v);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    localparam logic [7:0] CA [8] = '{8'h0E, 8'h10, 8'h12, 8'h14, 8'h16, 8'h1A, 8'h1C, 8'h1E};

    initial begin
        logic [63:0] ctrl_exp;
        repeat (5) @(negedge clk);
        check("R11 miso in reset", {63'd0, miso}, 64'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R11 led after reset", {60'd0, led}, 64'd0);
        check("R11 ctrl after reset", ctrl, 64'd0);
        check("R11 irq after reset", {63'd0, irq}, 64'd0);
        rd(8'h07, 8'h00, "R11 no flags from reset levels");

        rd(8'h01, 8'h3C, "R2 R1 version read");

        wr(8'h02, 8'hA7, "R9 miso zero on write");
        check("R3 led drive", {60'd0, led}, 64'hA);
        rd(8'h03, 8'hA0, "R3 led readback");

        rd(8'h05, 8'h5A, "R4 button levels");
        @(negedge clk) btn = 8'hC3;
        repeat (5) @(negedge clk);
        rd(8'h05, 8'hC3, "R4 button levels changed");
        wr(8'h06, 8'hFF, "R6 clear all");
        rd(8'h07, 8'h00, "R6 flags after full clear");

        rd(8'h09, 8'hE1, "R7 power good 0");
        rd(8'h0B, 8'h96, "R7 power good 1");
        rd(8'h0D, 8'hC3, "R7 power good 2");
        rd(8'h19, 8'h27, "R7 i2c select");

        ctrl_exp = '0;
        for (int k = 0; k < 8; k++) begin
            wr(CA[k], 8'(8'h11 * (k + 1)) ^ 8'h80, "R8 ctrl write");
            ctrl_exp[k*8 +: 8] = 8'(8'h11 * (k + 1)) ^ 8'h80;
        end
        check("R8 ctrl outputs", ctrl, ctrl_exp);
        for (int k = 0; k < 8; k++)
            rd(CA[k] | 8'h01, ctrl_exp[k*8 +: 8], "R8 ctrl readback");

        wr(8'h18, 8'h55, "R9 write unmapped");
        wr(8'h00, 8'h55, "R9 write nop");
        wr(8'h04, 8'h55, "R9 write unmapped low");
        xfer(8'h0F, 8'h55, 16, 8'h00, ctrl_exp[7:0], "R9 R1 read frame with data");
        check("R9 ctrl unchanged", ctrl, ctrl_exp);
        check("R9 led unchanged", {60'd0, led}, 64'hA);
        rd(8'h21, 8'h00, "R9 unmapped read");
        rd(8'hFF, 8'h00, "R9 unmapped read high");
        rd(8'h1B, ctrl_exp[47:40], "R8 warm reset readback");

        xfer(8'h0E, 8'h33, 12, 8'h00, 8'h00, "R10 abort");
        check("R10 aborted frame ignored", ctrl, ctrl_exp);
        xfer(8'h10, 8'h44, 24, 8'h99, 8'h00, "R10 long frame");
        ctrl_exp[15:8] = 8'h44;
        check("R10 extra bits ignored", ctrl, ctrl_exp);

        @(negedge clk) btn = 8'hC1;
        repeat (5) @(negedge clk);
        check("R5 irq set", {63'd0, irq}, 64'd1);
        rd(8'h07, 8'h02, "R5 flag bit1");
        @(negedge clk) btn = 8'h41;
        repeat (5) @(negedge clk);
        rd(8'h07, 8'h82, "R5 flag bit7 added");
        wr(8'h06, 8'h02, "R6 partial clear");
        rd(8'h07, 8'h80, "R6 other flag kept");
        check("R6 irq still set", {63'd0, irq}, 64'd1);
        wr(8'h06, 8'h80, "R6 clear last");
        check("R6 irq cleared", {63'd0, irq}, 64'd0);

        fork
            begin
                repeat (300) @(negedge clk) btn[0] = ~btn[0];
            end
            wr(8'h06, 8'h01, "R6 clear during toggling");
        join
        repeat (6) @(negedge clk);
        rd(8'h07, 8'h01, "R6 change beats clear");
        wr(8'h06, 8'h01, "R6 clear after toggling");
        rd(8'h07, 8'h00, "R6 flags empty");

        repeat (10) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule